// File: doc/BRIEF.md
# Sector-Staged SCSI Data Port

This block sits under a SCSI controller's register file and carries the data phases of a transfer through a one-sector staging buffer. When a command finishes, the target reports how many bytes it will move. That figure is loaded as a signed remaining count, and the byte pointer returns to zero. For a read, the block pulls up to one sector from the target over a valid/ready stream and then raises REQ. The CPU then takes the bytes one at a time through the current-data register. When the pointer passes the last byte of a full sector, the next sector is fetched, but only while bytes remain.

For a write, the CPU stores bytes through the output-data register while the bus is in the data-out phase and the initiator-command value selects buffered writes. Each completed sector is streamed to the target. When the remaining count is used up, the status byte takes its end-of-transfer code. While the block talks to the target, a busy flag holds off CPU accesses. A stalled access is completed once busy falls, so none is lost.

Top module: `sector_data_port`

## Requirements
- R1: After reset, busy, REQ, fill_ready, drain_valid, the status byte, the output-data register and cpu_rdata are all zero.
- R2: Loading a length L greater than zero sets the pointer to 0 and starts a fill of min(L, SECTOR_BYTES) bytes. fill_len shows that count, and busy is high until the last byte is taken. REQ is raised when the fill completes. When the count is below the sector size, the buffer byte at index count is cleared.
- R3: Loading a length of zero or less starts no fill, leaves busy low and clears REQ.
- R4: In the data-in phase (bus_phase = 3'b001), a CPU read returns the buffer byte at the pointer and then advances the pointer. When the remaining count is below the sector size, the pointer stops at count-1, so further reads repeat that byte.
- R5: In a full-sector read, the read of the last byte wraps the pointer to 0 and lowers the remaining count by SECTOR_BYTES. A new fill of min(remaining, SECTOR_BYTES) starts only if the new count is above zero. Otherwise a further read returns byte 0 and starts no fill.
- R6: In the data-out phase (bus_phase = 3'b000) with ini_cmd = 8'h01, each CPU write stores the byte at the pointer and advances the pointer. The write to the last index streams the whole sector to the target, in index order, over drain_valid/drain_ready.
- R7: When a drain completes, the pointer returns to 0 and the remaining count drops by SECTOR_BYTES. If the result is zero or less, the status byte becomes 8'hC8; otherwise it stays 8'h00. A length load clears it to 8'h00.
- R8: A buffered write leaves the output-data register at 0. Any other CPU write stores its byte in that register and does not touch the buffer or the pointer.
- R9: A CPU read or write presented while busy is high is held and is completed after busy falls, with its normal effect.
- R10: A CPU read outside the data-in phase returns the output-data register and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase | input | 3 | Current bus phase (000 data-out, 001 data-in) |
| ini_cmd | input | 8 | Initiator-command register value; 8'h01 selects buffered writes |
| len_load | input | 1 | Strobe: the command reported its transfer length |
| len_value | input | 32 | Signed transfer length |
| cpu_rd | input | 1 | CPU read of the current-data register, held until accepted |
| cpu_wr | input | 1 | CPU write of the output-data register, held until accepted |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned by the last accepted read |
| out_data | output | 8 | Output-data register readback |
| busy | output | 1 | Target exchange in progress; CPU accesses stall |
| req | output | 1 | REQ: sector data available |
| xfer_status | output | 8 | Bus-and-status byte (8'hC8 at end of transfer) |
| fill_len | output | SECTOR_BYTES bits log2 + 1 | Byte count of the current fill |
| fill_ready | output | 1 | Block accepts fill bytes |
| fill_valid | input | 1 | Target presents a fill byte |
| fill_data | input | 8 | Fill byte |
| drain_valid | output | 1 | Block presents a sector byte to the target |
| drain_ready | input | 1 | Target takes the drain byte |
| drain_data | output | 8 | Drain byte |

## Verification
On every cycle, the assertions check the handshake rules. A positive length starts a fill with the pointer at zero, and a non-positive one starts none. REQ follows the last fill byte, and a stalled read leaves cpu_rdata untouched. A buffered write clears the output register, the end code appears only out of a drain, and the stream index stays within its count. The data path itself needs the bench's scenarios. That covers the exact bytes returned across sector wraps, the pointer stopping on short transfers, and the order of drained bytes. It also covers the status value after each sector and the fact that unbuffered writes leave the buffer alone; the bench sweeps every short length and several multi-sector lengths.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } sdp_state_e;

  localparam logic [2:0] PH_DATA_OUT  = 3'b000;
  localparam logic [2:0] PH_DATA_IN   = 3'b001;
  localparam logic [7:0] INI_BUFFERED = 8'h01;
  localparam logic [7:0] END_CODE     = 8'hC8;
endpackage

// File: rtl/sdp_sector_buf.sv
module sdp_sector_buf #(
  parameter int BYTES = 512,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sdp_stream_seq.sv
module sdp_stream_seq #(
  parameter int AW = 9,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [LW-1:0] lim,
  output logic [AW-1:0] idx,
  output logic          last
);
  logic [AW-1:0] idx_q, idx_d;
  logic          idx_en;

  always_comb begin
    idx_en = clr | step;
    idx_d  = clr ? '0 : idx_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx  = idx_q;
  assign last = ({1'b0, idx_q} == (lim - LW'(1)));

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |-> ({1'b0, idx_q} < lim));
endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
#(
  parameter int BYTES = 512,
  parameter int CW    = 32,
  parameter int AW    = $clog2(BYTES),
  parameter int LW    = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           bus_phase,
  input  logic [7:0]           ini_cmd,
  input  logic                 len_load,
  input  logic signed [CW-1:0] len_value,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [7:0]           cpu_wdata,
  input  logic [7:0]           ptr_byte,
  input  logic                 fill_valid,
  input  logic [7:0]           fill_data,
  input  logic                 drain_ready,
  input  logic [AW-1:0]        seq_idx,
  input  logic                 seq_last,
  output logic [AW-1:0]        ptr,
  output logic                 buf_we,
  output logic [AW-1:0]        buf_waddr,
  output logic [7:0]           buf_wdata,
  output logic                 seq_clr,
  output logic                 seq_step,
  output logic [LW-1:0]        seq_lim,
  output logic [7:0]           cpu_rdata,
  output logic [7:0]           out_data,
  output logic                 busy,
  output logic                 req,
  output logic [7:0]           xfer_status,
  output logic [LW-1:0]        fill_len,
  output logic                 fill_ready,
  output logic                 drain_valid
);
  localparam logic [AW-1:0]        LAST    = AW'(BYTES - 1);
  localparam logic signed [CW-1:0] BYTES_S = CW'(BYTES);
  localparam logic signed [CW-1:0] ZERO_S  = '0;
  localparam logic signed [CW-1:0] ONE_S   = CW'(1);

  sdp_state_e             state_q, state_d;
  logic [AW-1:0]          ptr_q, ptr_d;
  logic signed [CW-1:0]   rem_q, rem_d, rem_wrap, ptr_ext;
  logic                   req_q, req_d;
  logic [7:0]             stat_q, stat_d, out_q, out_d, rdata_q, rdata_d;
  logic [LW-1:0]          flen_q, flen_d;
  logic                   idle, buffered;

  function automatic logic [LW-1:0] clamp_len(input logic signed [CW-1:0] v);
    if (v < BYTES_S) return v[LW-1:0];
    return LW'(BYTES);
  endfunction

  assign idle     = (state_q == ST_IDLE);
  assign buffered = (bus_phase == PH_DATA_OUT) && (ini_cmd == INI_BUFFERED);
  assign ptr_ext  = $signed({{(CW-AW){1'b0}}, ptr_q});
  assign rem_wrap = rem_q - BYTES_S;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    rem_d     = rem_q;
    req_d     = req_q;
    stat_d    = stat_q;
    out_d     = out_q;
    rdata_d   = rdata_q;
    flen_d    = flen_q;
    buf_we    = 1'b0;
    buf_waddr = ptr_q;
    buf_wdata = cpu_wdata;
    seq_clr   = 1'b0;
    seq_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (len_load) begin
          rem_d  = len_value;
          ptr_d  = '0;
          req_d  = 1'b0;
          stat_d = '0;
          if (len_value > ZERO_S) begin
            state_d = ST_FILL;
            seq_clr = 1'b1;
            flen_d  = clamp_len(len_value);
            if (len_value < BYTES_S) begin
              buf_we    = 1'b1;
              buf_waddr = len_value[AW-1:0];
              buf_wdata = '0;
            end
          end
        end else if (cpu_wr) begin
          if (buffered) begin
            buf_we = 1'b1;
            out_d  = '0;
            if (ptr_q == LAST) begin
              state_d = ST_DRAIN;
              seq_clr = 1'b1;
            end else begin
              ptr_d = ptr_q + AW'(1);
            end
          end else begin
            out_d = cpu_wdata;
          end
        end else if (cpu_rd) begin
          if (bus_phase == PH_DATA_IN) begin
            rdata_d = ptr_byte;
            if (rem_q < BYTES_S) begin
              if (ptr_ext < rem_q - ONE_S) ptr_d = ptr_q + AW'(1);
            end else if (ptr_q != LAST) begin
              ptr_d = ptr_q + AW'(1);
            end else begin
              ptr_d = '0;
              rem_d = rem_wrap;
              if (rem_wrap > ZERO_S) begin
                state_d = ST_FILL;
                seq_clr = 1'b1;
                flen_d  = clamp_len(rem_wrap);
                if (rem_wrap < BYTES_S) begin
                  buf_we    = 1'b1;
                  buf_waddr = rem_wrap[AW-1:0];
                  buf_wdata = '0;
                end
              end
            end
          end else begin
            rdata_d = out_q;
          end
        end
      end
      ST_FILL: begin
        if (fill_valid) begin
          buf_we    = 1'b1;
          buf_waddr = seq_idx;
          buf_wdata = fill_data;
          seq_step  = 1'b1;
          if (seq_last) begin
            state_d = ST_IDLE;
            req_d   = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (drain_ready) begin
          seq_step = 1'b1;
          if (seq_last) begin
            state_d = ST_IDLE;
            ptr_d   = '0;
            rem_d   = rem_wrap;
            if (rem_wrap <= ZERO_S) stat_d = END_CODE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      req_q   <= 1'b0;
      stat_q  <= '0;
      out_q   <= '0;
      rdata_q <= '0;
      flen_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      req_q   <= req_d;
      stat_q  <= stat_d;
      out_q   <= out_d;
      rdata_q <= rdata_d;
      flen_q  <= flen_d;
    end
  end

  assign ptr         = ptr_q;
  assign seq_lim     = (state_q == ST_DRAIN) ? LW'(BYTES) : flen_q;
  assign cpu_rdata   = rdata_q;
  assign out_data    = out_q;
  assign busy        = !idle;
  assign req         = req_q;
  assign xfer_status = stat_q;
  assign fill_len    = flen_q;
  assign fill_ready  = (state_q == ST_FILL);
  assign drain_valid = (state_q == ST_DRAIN);

  assert_pos_len_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && len_load && len_value > ZERO_S) |=> (fill_ready && ptr_q == '0));
  assert_req_after_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ready && fill_valid && seq_last) |=> (req && !busy));
  assert_no_fill_nonpos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && len_load && len_value <= ZERO_S) |=> (!fill_ready && !req));
  assert_end_from_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_status == END_CODE) |-> $past(state_q == ST_DRAIN));
  assert_buffered_clears_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !len_load && cpu_wr && buffered) |=> (out_data == 8'h00));
  assert_stall_holds_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_rd) |=> $stable(cpu_rdata));
endmodule

// File: rtl/sector_data_port.sv
module sector_data_port #(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 32,
  localparam int AW          = $clog2(SECTOR_BYTES),
  localparam int LW          = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              bus_phase,
  input  logic [7:0]              ini_cmd,
  input  logic                    len_load,
  input  logic signed [CNT_W-1:0] len_value,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [7:0]              cpu_wdata,
  output logic [7:0]              cpu_rdata,
  output logic [7:0]              out_data,
  output logic                    busy,
  output logic                    req,
  output logic [7:0]              xfer_status,
  output logic [LW-1:0]           fill_len,
  output logic                    fill_ready,
  input  logic                    fill_valid,
  input  logic [7:0]              fill_data,
  output logic                    drain_valid,
  input  logic                    drain_ready,
  output logic [7:0]              drain_data
);
  logic          rst_meta_q, rst_sync_q;
  logic [AW-1:0] ptr, seq_idx, buf_waddr;
  logic          buf_we, seq_clr, seq_step, seq_last;
  logic [7:0]    buf_wdata, ptr_byte;
  logic [LW-1:0] seq_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sdp_sector_buf #(.BYTES(SECTOR_BYTES), .AW(AW)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (ptr),
    .rdata_a (ptr_byte),
    .raddr_b (seq_idx),
    .rdata_b (drain_data)
  );

  sdp_stream_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (seq_clr),
    .step  (seq_step),
    .lim   (seq_lim),
    .idx   (seq_idx),
    .last  (seq_last)
  );

  sdp_ctrl #(.BYTES(SECTOR_BYTES), .CW(CNT_W), .AW(AW), .LW(LW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_phase   (bus_phase),
    .ini_cmd     (ini_cmd),
    .len_load    (len_load),
    .len_value   (len_value),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .ptr_byte    (ptr_byte),
    .fill_valid  (fill_valid),
    .fill_data   (fill_data),
    .drain_ready (drain_ready),
    .seq_idx     (seq_idx),
    .seq_last    (seq_last),
    .ptr         (ptr),
    .buf_we      (buf_we),
    .buf_waddr   (buf_waddr),
    .buf_wdata   (buf_wdata),
    .seq_clr     (seq_clr),
    .seq_step    (seq_step),
    .seq_lim     (seq_lim),
    .cpu_rdata   (cpu_rdata),
    .out_data    (out_data),
    .busy        (busy),
    .req         (req),
    .xfer_status (xfer_status),
    .fill_len    (fill_len),
    .fill_ready  (fill_ready),
    .drain_valid (drain_valid)
  );
endmodule

// File: tb/sector_data_port_bench.sv
module sector_data_port_bench;
  localparam int S  = 16;
  localparam int LW = $clog2(S) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        bus_phase = 3'b001;
  logic [7:0]        ini_cmd = 8'h00;
  logic              len_load = 1'b0;
  logic signed [31:0] len_value = '0;
  logic              cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]        cpu_wdata = '0;
  logic [7:0]        cpu_rdata, out_data, xfer_status, drain_data;
  logic              busy, req, fill_ready, drain_valid;
  logic [LW-1:0]     fill_len;
  logic              fill_valid = 1'b0, drain_ready = 1'b0;
  logic [7:0]        fill_data = '0;

  int checks = 0, errors = 0;
  int mdl [S];
  int cap [S];
  int wexp [S];
  int fl_log [64];
  int nfill = 0, fcnt = 0, fsec = 0, dcnt = 0, cyc = 0;
  logic prev_fr = 1'b0;

  always #4 clk = ~clk;

  sector_data_port #(.SECTOR_BYTES(S), .CNT_W(32)) u_sector_data_port (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .ini_cmd(ini_cmd),
    .len_load(len_load), .len_value(len_value), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .out_data(out_data), .busy(busy),
    .req(req), .xfer_status(xfer_status), .fill_len(fill_len), .fill_ready(fill_ready),
    .fill_valid(fill_valid), .fill_data(fill_data), .drain_valid(drain_valid),
    .drain_ready(drain_ready), .drain_data(drain_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model: fill source and drain sink, stepped on falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (fill_ready && !prev_fr) begin
        fcnt = 0;
        fsec++;
        if (nfill < 64) fl_log[nfill] = int'(fill_len);
        nfill++;
      end
      prev_fr = fill_ready;
      fill_valid = (cyc % 3) != 2;
      fill_data = 8'((fsec * 37 + fcnt * 5 + 3) & 255);
      if (fill_ready && fill_valid) begin
        if (fcnt < S) mdl[fcnt] = int'(fill_data);
        fcnt++;
      end
      drain_ready = (cyc % 4) != 1;
      if (drain_valid && drain_ready) begin
        if (dcnt < S) cap[dcnt] = int'(drain_data);
        dcnt++;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_load(input int v);
    wait_idle();
    len_load = 1'b1;
    len_value = v;
    @(negedge clk);
    len_load = 1'b0;
  endtask

  task automatic do_read(output int d);
    @(negedge clk);
    cpu_rd = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    cpu_rd = 1'b0;
    d = int'(cpu_rdata);
  endtask

  task automatic do_write(input int v);
    @(negedge clk);
    cpu_wr = 1'b1;
    cpu_wdata = 8'(v);
    while (busy) @(negedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic run_read(input int len);
    int start, rem, sect, n, d, e;
    bit done;
    bus_phase = 3'b001;
    start = nfill;
    do_load(len);
    rem = len;
    sect = 0;
    done = 0;
    while (!done) begin
      wait_idle();
      n = (rem < S) ? rem : S;
      chk("R2 fill length", fl_log[nfill-1], n);
      chk("R2 REQ after fill", int'(req), 1);
      for (int i = 0; i < n; i++) begin
        e = mdl[i];
        do_read(d);
        chk("R4 read byte at pointer", d, e);
      end
      if (n < S) begin
        for (int k = 0; k < 2; k++) begin
          do_read(d);
          chk("R4 pointer holds at count-1", d, mdl[n-1]);
        end
        done = 1;
      end else begin
        rem = rem - S;
        sect++;
        if (rem <= 0) begin
          wait_idle();
          chk("R5 no refill when count spent", nfill - start, sect);
          e = mdl[0];
          do_read(d);
          chk("R5 pointer wrapped to 0", d, e);
          chk("R5 still no fill", nfill - start, sect);
          done = 1;
        end
      end
    end
  endtask

  task automatic run_write(input int len, input int nsect);
    int rem;
    bus_phase = 3'b001;
    do_load(len);
    wait_idle();
    chk("R7 load clears status", int'(xfer_status), 0);
    rem = len;
    for (int s = 0; s < nsect; s++) begin
      bus_phase = 3'b000;
      ini_cmd = 8'h01;
      dcnt = 0;
      for (int i = 0; i < S; i++) begin
        wexp[i] = (s * 29 + i * 11 + 64 + len) & 255;
        do_write(wexp[i]);
        if (i == 0) chk("R8 buffered write reads back 0", int'(out_data), 0);
        if (i == 3) begin
          ini_cmd = 8'h05;
          do_write(8'h77);
          chk("R8 unbuffered write kept", int'(out_data), 8'h77);
          chk("R8 unbuffered write no drain", int'(busy), 0);
          ini_cmd = 8'h01;
        end
      end
      wait_idle();
      chk("R6 drained byte count", dcnt, S);
      for (int i = 0; i < S; i++) chk("R6 drained byte order", cap[i], wexp[i]);
      rem = rem - S;
      chk("R7 status after drain", int'(xfer_status), (rem <= 0) ? 8'hC8 : 0);
    end
    bus_phase = 3'b001;
    ini_cmd = 8'h00;
  endtask

  initial begin
    int d, e, nf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 fill_ready", int'(fill_ready), 0);
    chk("R1 drain_valid", int'(drain_valid), 0);
    chk("R1 status", int'(xfer_status), 0);
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 cpu_rdata", int'(cpu_rdata), 0);

    for (int L = 1; L <= S + 2; L++) run_read(L);
    run_read(2 * S + 3);
    run_read(3 * S);

    // R3: non-positive lengths
    nf = nfill;
    do_load(0);
    chk("R3 zero length busy", int'(busy), 0);
    chk("R3 zero length clears REQ", int'(req), 0);
    do_load(-5);
    @(negedge clk);
    chk("R3 negative length busy", int'(busy), 0);
    chk("R3 no fill started", nfill - nf, 0);

    // R10 and R8: unbuffered write, read outside data-in
    bus_phase = 3'b001;
    do_write(8'h5A);
    chk("R8 write outside data-out kept", int'(out_data), 8'h5A);
    bus_phase = 3'b010;
    do_read(d);
    chk("R10 read outside data-in", d, 8'h5A);

    // R10: pointer untouched by reads in another phase
    bus_phase = 3'b001;
    do_load(S);
    wait_idle();
    do_read(d);
    e = mdl[1];
    bus_phase = 3'b011;
    do_read(d);
    bus_phase = 3'b001;
    do_read(d);
    chk("R10 pointer not moved", d, e);

    // R9: read issued during a fill is held then completed
    do_load(7);
    chk("R9 busy during fill", int'(busy), 1);
    do_read(d);
    chk("R9 stalled read returns first byte", d, mdl[0]);
    do_read(d);
    chk("R9 next read advances", d, mdl[1]);

    run_write(2 * S, 2);
    run_write(S + 3, 2);
    run_write(S, 1);
    run_write(1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1-wide actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule